// File: doc/BRIEF.md
# PHY Interrupt Cause Register with Clear-on-Read

This block holds the pending interrupt causes of an Ethernet PHY in one 16-bit management register. Single-cycle pulses arrive from the PHY's event monitors: speed, link, duplex, autonegotiation error and completion, symbol error, fast link failure, false carrier, downshift, master/slave resolution fault and receive error. Each pulse sets a sticky bit. Bit 15 summarises the pending causes. Some causes are qualified by control conditions that the block samples in the same cycle as the pulse.

A management agent reads the register with a one-cycle strobe `rd_en` and a 5-bit address. The block answers every strobe one cycle later with `rd_valid` and `rd_data`. When the address matches the register address (default 26), the data is the snapshot pending at the strobe edge, and every bit in that snapshot is cleared. A pulse that arrives on the same edge is kept for the next read. Any other address returns zero and leaves the register untouched.

A small response sequencer has two states. `RS_IDLE` waits for a strobe. `RS_RESP` presents a response. The transitions are: IDLE→RESP on a strobe (`T_ACCEPT`), RESP→RESP on a back-to-back strobe (`T_CHAIN`), and RESP→IDLE when no strobe is present (`T_DONE`).

Top module: `phy_irq_status`

## Requirements
- R1: After reset every bit of the register is 0, so the first read at address 26 returns 0x0000.
- R2: Each cause sets its own bit: speed 14, link 13, duplex 12, autoneg error 11, autoneg complete 10, symbol error 8, fast link failure 7, false carrier 3, downshift 2, master/slave fault 1, receive error 0.
- R3: Bit 15 of the returned data is 1 exactly when any of bits 14:0 in the same data is 1.
- R4: Bits 9, 6, 5 and 4 always read 0.
- R5: A read at address 26 clears every bit it returned, so an immediate second read returns 0x0000.
- R6: A pulse on the same edge as a clearing read is not part of that read's data, but it is returned by the next read.
- R7: The speed cause (bit 14) and the duplex cause (bit 12) set only when `an_enable` is 1 in the pulse cycle.
- R8: The downshift cause (bit 2) sets only when all four bits of `adv_bits` are 1 in the pulse cycle.
- R9: The receive error cause (bit 0) does not set while `carrier_ext` is 1 in the pulse cycle.
- R10: A read at any other address returns 0x0000 and clears nothing.
- R11: `rd_valid` is 1 in the single cycle after each accepted strobe and 0 otherwise.
- R12: Causes pulsed in different cycles accumulate until a clearing read returns them together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 5 | Register address of the access |
| rd_valid | output | 1 | Response valid, one cycle after the strobe |
| rd_data | output | 16 | Response data |
| ev_speed | input | 1 | Speed change pulse |
| ev_link | input | 1 | Link change pulse |
| ev_duplex | input | 1 | Duplex change pulse |
| ev_an_err | input | 1 | Autonegotiation error pulse |
| ev_an_done | input | 1 | Autonegotiation complete pulse |
| ev_sym_err | input | 1 | Symbol error pulse |
| ev_fast_fail | input | 1 | Fast link failure pulse |
| ev_false_car | input | 1 | False carrier pulse |
| ev_downshift | input | 1 | Speed downshift pulse |
| ev_ms_fault | input | 1 | Master/slave resolution fault pulse |
| ev_rx_err | input | 1 | Receive error pulse |
| an_enable | input | 1 | Autonegotiation enabled (control condition) |
| adv_bits | input | 4 | Advertised ability bits that qualify downshift |
| carrier_ext | input | 1 | Receive error line is decoding carrier extension |

## Verification
The hardest case to reach is a cause pulse on the exact edge where a clearing read samples the register. If the ordering is wrong, the cause is either reported twice or lost. The stimulus raises the pulse and the strobe on the same falling edge. It then checks that the first response lacks the bit and that the second response carries it. The gating conditions are also tested at their edges: three of four advertisement bits set, and carrier extension asserted together with a receive error.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int CAUSE_W = 15;
    localparam int DATA_W  = CAUSE_W + 1;

    localparam int B_SPEED    = 14;
    localparam int B_LINK     = 13;
    localparam int B_DUPLEX   = 12;
    localparam int B_AN_ERR   = 11;
    localparam int B_AN_DONE  = 10;
    localparam int B_SYM_ERR  = 8;
    localparam int B_FAST     = 7;
    localparam int B_FALSECAR = 3;
    localparam int B_DOWNSH   = 2;
    localparam int B_MS_FAULT = 1;
    localparam int B_RX_ERR   = 0;

    localparam logic [CAUSE_W-1:0] RSVD_MASK = 15'h0270;

    typedef enum logic [0:0] {
        RS_IDLE = 1'b0,
        RS_RESP = 1'b1
    } rsp_state_t;

endpackage

// File: rtl/irq_cause_gate.sv
module irq_cause_gate
    import phy_irq_pkg::*;
#(
    parameter int ADV_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] raw_ev,
    input  logic               an_enable,
    input  logic [ADV_W-1:0]   adv_bits,
    input  logic               carrier_ext,
    output logic [CAUSE_W-1:0] set_ev
);

    logic adv_all;

    always_comb begin
        adv_all = &adv_bits;
        set_ev  = raw_ev & ~RSVD_MASK;
        if (!an_enable) begin
            set_ev[B_SPEED]  = 1'b0;
            set_ev[B_DUPLEX] = 1'b0;
        end
        if (!adv_all) begin
            set_ev[B_DOWNSH] = 1'b0;
        end
        if (carrier_ext) begin
            set_ev[B_RX_ERR] = 1'b0;
        end
    end

    AST_GATE_SPEED_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        !an_enable |-> !set_ev[B_SPEED] && !set_ev[B_DUPLEX]); // R7
    AST_GATE_DOWNSHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_bits != {ADV_W{1'b1}}) |-> !set_ev[B_DOWNSH]); // R8
    AST_GATE_RXER: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_ext |-> !set_ev[B_RX_ERR]); // R9

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
    import phy_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] set_ev,
    input  logic               clr,
    output logic [CAUSE_W-1:0] pending
);

    logic [CAUSE_W-1:0] pend_q;

    for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
        localparam logic KEEP = ~RSVD_MASK[i];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else begin
                pend_q[i] <= KEEP & (set_ev[i] | (pend_q[i] & ~clr));
            end
        end
    end

    assign pending = pend_q;

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_ev == '0) |=> pending == '0); // R5
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((pending & $past(pending)) == $past(pending))); // R12
    AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & RSVD_MASK) == '0); // R4

endmodule

// File: rtl/irq_read_seq.sv
module irq_read_seq
    import phy_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               addr_hit,
    input  logic [CAUSE_W-1:0] pending,
    output logic               clr,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data
);

    rsp_state_t state_q, state_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (rd_en) state_d = RS_RESP;
            RS_RESP: state_d = rd_en ? RS_RESP : RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_en) begin
            data_q <= addr_hit ? {|pending, pending} : '0;
        end else begin
            data_q <= '0;
        end
    end

    always_comb begin
        clr      = rd_en & addr_hit;
        rd_valid = (state_q == RS_RESP);
        rd_data  = data_q;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R11
    AST_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R11
    AST_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> rd_data[DATA_W-1] == (|rd_data[DATA_W-2:0])); // R3

endmodule

// File: rtl/phy_irq_status.sv
module phy_irq_status
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 26,
    parameter int ADV_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    input  logic              ev_speed,
    input  logic              ev_link,
    input  logic              ev_duplex,
    input  logic              ev_an_err,
    input  logic              ev_an_done,
    input  logic              ev_sym_err,
    input  logic              ev_fast_fail,
    input  logic              ev_false_car,
    input  logic              ev_downshift,
    input  logic              ev_ms_fault,
    input  logic              ev_rx_err,
    input  logic              an_enable,
    input  logic [ADV_W-1:0]  adv_bits,
    input  logic              carrier_ext
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

    logic [CAUSE_W-1:0] raw_ev;
    logic [CAUSE_W-1:0] set_ev;
    logic [CAUSE_W-1:0] pending;
    logic               clr;
    logic               addr_hit;

    always_comb begin
        raw_ev             = '0;
        raw_ev[B_SPEED]    = ev_speed;
        raw_ev[B_LINK]     = ev_link;
        raw_ev[B_DUPLEX]   = ev_duplex;
        raw_ev[B_AN_ERR]   = ev_an_err;
        raw_ev[B_AN_DONE]  = ev_an_done;
        raw_ev[B_SYM_ERR]  = ev_sym_err;
        raw_ev[B_FAST]     = ev_fast_fail;
        raw_ev[B_FALSECAR] = ev_false_car;
        raw_ev[B_DOWNSH]   = ev_downshift;
        raw_ev[B_MS_FAULT] = ev_ms_fault;
        raw_ev[B_RX_ERR]   = ev_rx_err;
        addr_hit           = (rd_addr == HIT_ADDR);
    end

    irq_cause_gate #(.ADV_W(ADV_W)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_ev      (raw_ev),
        .an_enable   (an_enable),
        .adv_bits    (adv_bits),
        .carrier_ext (carrier_ext),
        .set_ev      (set_ev)
    );

    irq_latch_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (set_ev),
        .clr     (clr),
        .pending (pending)
    );

    irq_read_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .addr_hit (addr_hit),
        .pending  (pending),
        .clr      (clr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    AST_OTHER_ADDR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr_hit) |=> ((pending & $past(pending)) == $past(pending))); // R10
    AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr_hit) |=> rd_data == 16'h0000); // R10
    AST_SAME_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && set_ev[B_LINK]) |=> pending[B_LINK]); // R6

endmodule

// File: tb/tb_phy_irq_status.sv
module tb_phy_irq_status;

    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_IRQ = 5'd26;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic [14:0] ev = '0;
    logic        an_enable = 1'b1;
    logic [3:0]  adv_bits = 4'hF;
    logic        carrier_ext = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_irq_status dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ev_speed(ev[14]), .ev_link(ev[13]), .ev_duplex(ev[12]),
        .ev_an_err(ev[11]), .ev_an_done(ev[10]), .ev_sym_err(ev[8]),
        .ev_fast_fail(ev[7]), .ev_false_car(ev[3]), .ev_downshift(ev[2]),
        .ev_ms_fault(ev[1]), .ev_rx_err(ev[0]),
        .an_enable(an_enable), .adv_bits(adv_bits), .carrier_ext(carrier_ext)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [14:0] m);
        @(negedge clk);
        ev = m;
        @(negedge clk);
        ev = '0;
    endtask

    // strobe one read; returns data sampled at the following falling edge
    task automatic do_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check("R11 valid", {15'b0, rd_valid}, 16'h0001);
        check("R4 reserved", rd_data & 16'h0270, 16'h0000);
        check("R3 summary", {15'b0, rd_data[15]}, {15'b0, |rd_data[14:0]});
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R11 idle", {15'b0, rd_valid}, 16'h0000);
        do_read(A_IRQ, d);
        check("R1 reset", d, 16'h0000);
        @(negedge clk);
        check("R11 drop", {15'b0, rd_valid}, 16'h0000);
    endtask

    task automatic t_each_cause();
        logic [15:0] d;
        int bits [11] = '{14, 13, 12, 11, 10, 8, 7, 3, 2, 1, 0};
        foreach (bits[k]) begin
            logic [14:0] m = 15'(1) << bits[k];
            pulse(m);
            do_read(A_IRQ, d);
            check("R2 cause bit", d, {1'b1, m});
            do_read(A_IRQ, d);
            check("R5 cleared", d, 16'h0000);
        end
    endtask

    task automatic t_reserved_inputs();
        logic [15:0] d;
        do_read(A_IRQ, d);
        check("R4 reserved read", d, 16'h0000);
    endtask

    task automatic t_gate_an();
        logic [15:0] d;
        an_enable = 1'b0;
        pulse(15'h5000);
        an_enable = 1'b1;
        do_read(A_IRQ, d);
        check("R7 gated off", d, 16'h0000);
        pulse(15'h5000);
        do_read(A_IRQ, d);
        check("R7 gated on", d, 16'hD000);
    endtask

    task automatic t_gate_adv();
        logic [15:0] d;
        adv_bits = 4'b1110;
        pulse(15'h0004);
        adv_bits = 4'b0111;
        pulse(15'h0004);
        adv_bits = 4'hF;
        do_read(A_IRQ, d);
        check("R8 partial adv", d, 16'h0000);
        pulse(15'h0004);
        do_read(A_IRQ, d);
        check("R8 full adv", d, 16'h8004);
    endtask

    task automatic t_gate_cext();
        logic [15:0] d;
        carrier_ext = 1'b1;
        pulse(15'h0009);
        carrier_ext = 1'b0;
        do_read(A_IRQ, d);
        check("R9 suppressed", d, 16'h8008);
    endtask

    task automatic t_same_edge();
        logic [15:0] d;
        pulse(15'h0100);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = A_IRQ;
        ev = 15'h2000;
        @(negedge clk);
        rd_en = 1'b0;
        ev = '0;
        check("R6 first read", rd_data, 16'h8100);
        do_read(A_IRQ, d);
        check("R6 second read", d, 16'hA000);
    endtask

    task automatic t_other_addr();
        logic [15:0] d;
        pulse(15'h0080);
        do_read(5'd3, d);
        check("R10 other data", d, 16'h0000);
        do_read(5'd27, d);
        check("R10 other data 2", d, 16'h0000);
        do_read(A_IRQ, d);
        check("R10 kept", d, 16'h8080);
    endtask

    task automatic t_accumulate();
        logic [15:0] d;
        pulse(15'h0800);
        pulse(15'h0400);
        pulse(15'h0002);
        do_read(A_IRQ, d);
        check("R12 accumulate", d, 16'h8C02);
        do_read(A_IRQ, d);
        check("R5 accumulate clear", d, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid low", {15'b0, rd_valid}, 16'h0000);
        check("R1 data low", rd_data, 16'h0000);
        rst_n = 1'b1;
        t_reset();
        t_each_cause();
        t_reserved_inputs();
        t_gate_an();
        t_gate_adv();
        t_gate_cext();
        t_same_edge();
        t_other_addr();
        t_accumulate();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule